// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable waveforms for a parallel RGB panel. It also reports the current pixel position and marks the first pixel of every frame. It runs on the system clock and advances by one pixel position on each cycle where the pixel-clock enable is high. Its geometry comes from two packed 32-bit timing words. Separate control inputs invert each output's polarity and pick the launch edge for pixel data.

Each line is counted as four phases in a fixed order: active pixels, front porch, sync pulse, back porch. The vertical axis counts completed lines through the same four phases. The line width is coded in units of 16 pixels. The horizontal porches and sync width are stored minus one. The vertical porches are stored as plain line counts.

The block does nothing unless its enable input is high. While enable is low, both counters are cleared and every timing output sits at its inactive level. The panel-power output follows the power input only while the block is enabled, so software raises enable first and power second.

Top module: `lcd_raster_timing`

## Requirements
- R1: The active width is 16*(hcfg[7:2]+1) pixels. `de` is at its active level exactly when the block is enabled, `px_x` is below that width, and `px_y` is below the active line count.
- R2: After the active pixels, a line has a front porch of hcfg[23:16]+1 pixels, then a sync of hcfg[15:8]+1 pixels, then a back porch of hcfg[31:24]+1 pixels. `hsync` is active only during the sync pixels.
- R3: A frame has vcfg[9:0]+1 active lines, then vcfg[23:16] front-porch lines, then vcfg[15:10]+1 sync lines, then vcfg[31:24] back-porch lines. The two porch counts are used directly, with no offset, and zero is allowed. `vsync` is active only during the sync lines.
- R4: While enabled, `px_x` advances by one on each clock edge where `pix_ce` is high and holds its value otherwise. At the last pixel of a line, `px_x` returns to 0 and `px_y` advances by one. `px_y` returns to 0 after the last line of the frame.
- R5: `frame_start` is high exactly when the block is enabled and both `px_x` and `px_y` are 0.
- R6: When `inv_hs`, `inv_vs` or `inv_de` is 1, the matching output is active low. When it is 0, the output is active high.
- R7: While `ctrl_en` is 0, both counters clear to 0 at the next clock edge and stay there. `hsync`, `vsync` and `de` are held at their inactive levels, and `frame_start` is 0.
- R8: `panel_pwr` is high only when both `ctrl_en` and `ctrl_pwr` are 1. With `ctrl_en` at 0, the power input has no effect.
- R9: `data_fall` (1 means pixel data is launched on the falling pixel-clock edge) follows `edge_fall` while the block is enabled, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable; one pixel position per high cycle |
| hcfg | input | 32 | Horizontal timing word (width, sync, porches) |
| vcfg | input | 32 | Vertical timing word (lines, sync, porches) |
| ctrl_en | input | 1 | Block enable |
| ctrl_pwr | input | 1 | Panel power request |
| inv_hs | input | 1 | Make hsync active low |
| inv_vs | input | 1 | Make vsync active low |
| inv_de | input | 1 | Make data enable active low |
| edge_fall | input | 1 | Select falling-edge data launch |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | 11 | Current pixel position within the line |
| px_y | output | 11 | Current line within the frame |
| frame_start | output | 1 | High at pixel 0 of line 0 |
| panel_pwr | output | 1 | Panel power output |
| data_fall | output | 1 | Launch-edge select toward the panel |

## Verification
The pixel counters are the only state. Every other output is decoded from the counters and the control inputs, with no further register. A `pix_ce` cycle or an enable change therefore shows up on all outputs at the first clock edge after the inputs are applied. A polarity or power change is visible before that edge. The bench drives inputs on the falling edge and updates its reference position one step per rising edge. It then compares every output slightly after that rising edge, so each result is checked in the cycle it is due.

// File: rtl/lcd_tmg_pkg.sv
`timescale 1ns/1ps
package lcd_tmg_pkg;
    // counter width covers the largest possible line or frame
    localparam int CNT_W      = 11;
    localparam int UNIT_SHIFT = 4;   // line width unit of 16 pixels
    // horizontal word fields
    localparam int WID_LSB    = 2;
    localparam int WID_W      = 6;
    localparam int HSW_LSB    = 8;
    localparam int HFP_LSB    = 16;
    localparam int HBP_LSB    = 24;
    localparam int PORCH_W    = 8;
    // vertical word fields
    localparam int LIN_LSB    = 0;
    localparam int LIN_W      = 10;
    localparam int VSW_LSB    = 10;
    localparam int VSW_W      = 6;
    localparam int VFP_LSB    = 16;
    localparam int VBP_LSB    = 24;

    typedef struct packed {
        logic [CNT_W-1:0] act_end;   // first position after the active phase
        logic [CNT_W-1:0] fp_end;    // first sync position
        logic [CNT_W-1:0] sync_end;  // first back porch position
        logic [CNT_W-1:0] total;     // positions per period
    } axis_cfg_t;
endpackage

// File: rtl/lcd_tmg_decode.sv
`timescale 1ns/1ps
module lcd_tmg_decode
    import lcd_tmg_pkg::*;
(
    input  logic [31:0] hcfg,
    input  logic [31:0] vcfg,
    output axis_cfg_t   h_cfg,
    output axis_cfg_t   v_cfg
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic unused_low_bits;
    assign unused_low_bits = ^hcfg[WID_LSB-1:0];

    always_comb begin
        // horizontal: every field is stored minus one
        h_cfg.act_end  = (CNT_W'(hcfg[WID_LSB +: WID_W]) + ONE) << UNIT_SHIFT;
        h_cfg.fp_end   = h_cfg.act_end  + CNT_W'(hcfg[HFP_LSB +: PORCH_W]) + ONE;
        h_cfg.sync_end = h_cfg.fp_end   + CNT_W'(hcfg[HSW_LSB +: PORCH_W]) + ONE;
        h_cfg.total    = h_cfg.sync_end + CNT_W'(hcfg[HBP_LSB +: PORCH_W]) + ONE;
        // vertical: line count and sync minus one, porches direct
        v_cfg.act_end  = CNT_W'(vcfg[LIN_LSB +: LIN_W]) + ONE;
        v_cfg.fp_end   = v_cfg.act_end  + CNT_W'(vcfg[VFP_LSB +: PORCH_W]);
        v_cfg.sync_end = v_cfg.fp_end   + CNT_W'(vcfg[VSW_LSB +: VSW_W]) + ONE;
        v_cfg.total    = v_cfg.sync_end + CNT_W'(vcfg[VBP_LSB +: PORCH_W]);
    end
endmodule

// File: rtl/lcd_tmg_axis.sv
`timescale 1ns/1ps
module lcd_tmg_axis #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] total,
    output logic [W-1:0] count,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] count;
    } axis_state_t;

    axis_state_t st_d, st_q;
    logic        at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.count >= (total - W'(1)));
        wrap    = !clear && step && at_last;
        if (clear)
            st_d.count = '0;
        else if (step)
            st_d.count = at_last ? '0 : st_q.count + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R7
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(count)); // R4
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0)); // R4
endmodule

// File: rtl/lcd_tmg_window.sv
`timescale 1ns/1ps
module lcd_tmg_window
    import lcd_tmg_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  axis_cfg_t        cfg,
    output logic             in_act,
    output logic             in_sync
);
    logic unused_total;
    assign unused_total = ^cfg.total;

    always_comb begin
        in_act  = (count < cfg.act_end);
        in_sync = (count >= cfg.fp_end) && (count < cfg.sync_end);
    end
endmodule

// File: rtl/lcd_raster_timing.sv
`timescale 1ns/1ps
module lcd_raster_timing
    import lcd_tmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ce,
    input  logic [31:0]      hcfg,
    input  logic [31:0]      vcfg,
    input  logic             ctrl_en,
    input  logic             ctrl_pwr,
    input  logic             inv_hs,
    input  logic             inv_vs,
    input  logic             inv_de,
    input  logic             edge_fall,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CNT_W-1:0] px_x,
    output logic [CNT_W-1:0] px_y,
    output logic             frame_start,
    output logic             panel_pwr,
    output logic             data_fall
);
    axis_cfg_t        h_cfg, v_cfg;
    logic             h_wrap, v_wrap_unused;
    logic             h_act, h_sync, v_act, v_sync;
    logic [CNT_W-1:0] x_cnt, y_cnt;

    lcd_tmg_decode i_decode (
        .hcfg  (hcfg),
        .vcfg  (vcfg),
        .h_cfg (h_cfg),
        .v_cfg (v_cfg)
    );

    lcd_tmg_axis #(.W(CNT_W)) i_haxis (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!ctrl_en),
        .step  (ctrl_en && pix_ce),
        .total (h_cfg.total),
        .count (x_cnt),
        .wrap  (h_wrap)
    );

    lcd_tmg_axis #(.W(CNT_W)) i_vaxis (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!ctrl_en),
        .step  (h_wrap),
        .total (v_cfg.total),
        .count (y_cnt),
        .wrap  (v_wrap_unused)
    );

    lcd_tmg_window i_hwin (
        .count   (x_cnt),
        .cfg     (h_cfg),
        .in_act  (h_act),
        .in_sync (h_sync)
    );

    lcd_tmg_window i_vwin (
        .count   (y_cnt),
        .cfg     (v_cfg),
        .in_act  (v_act),
        .in_sync (v_sync)
    );

    always_comb begin
        hsync       = (ctrl_en && h_sync) ^ inv_hs;
        vsync       = (ctrl_en && v_sync) ^ inv_vs;
        de          = (ctrl_en && h_act && v_act) ^ inv_de;
        frame_start = ctrl_en && (x_cnt == '0) && (y_cnt == '0);
        panel_pwr   = ctrl_en && ctrl_pwr;
        data_fall   = ctrl_en && edge_fall;
        px_x        = x_cnt;
        px_y        = y_cnt;
    end

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (hsync == inv_hs && vsync == inv_vs && de == inv_de && !frame_start)); // R7
    AST_START_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (px_x == '0 && px_y == '0)); // R5
    AST_PWR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        panel_pwr |-> ctrl_en); // R8
    AST_DE_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (de != inv_de) |-> (px_x < h_cfg.act_end && px_y < v_cfg.act_end)); // R1
    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !h_wrap) |=> $stable(px_y)); // R4
    AST_HS_OUTSIDE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync != inv_hs) |-> (px_x >= h_cfg.act_end)); // R2
    AST_VS_OUTSIDE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync != inv_vs) |-> (px_y >= v_cfg.act_end)); // R3
endmodule

// File: tb/test_lcd_raster_timing.sv
`timescale 1ns/1ps
module test_lcd_raster_timing;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b0;
    logic [31:0] hcfg = '0;
    logic [31:0] vcfg = '0;
    logic        ctrl_en = 1'b0, ctrl_pwr = 1'b0;
    logic        inv_hs = 1'b0, inv_vs = 1'b0, inv_de = 1'b0, edge_fall = 1'b0;
    logic        hsync, vsync, de, frame_start, panel_pwr, data_fall;
    logic [10:0] px_x, px_y;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int mx = 0, my = 0;
    int c_wid, c_hfp, c_hsw, c_hbp, c_lin, c_vfp, c_vsw, c_vbp;

    always #2.5 clk = ~clk;

    lcd_raster_timing i_lcd_raster_timing (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .hcfg(hcfg), .vcfg(vcfg),
        .ctrl_en(ctrl_en), .ctrl_pwr(ctrl_pwr), .inv_hs(inv_hs), .inv_vs(inv_vs),
        .inv_de(inv_de), .edge_fall(edge_fall), .hsync(hsync), .vsync(vsync),
        .de(de), .px_x(px_x), .px_y(px_y), .frame_start(frame_start),
        .panel_pwr(panel_pwr), .data_fall(data_fall)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired: actual=%0d cycles expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int h_act();  return 16 * (c_wid + 1); endfunction
    function automatic int h_fpe();  return h_act() + c_hfp + 1; endfunction
    function automatic int h_sye();  return h_fpe() + c_hsw + 1; endfunction
    function automatic int h_tot();  return h_sye() + c_hbp + 1; endfunction
    function automatic int v_act();  return c_lin + 1; endfunction
    function automatic int v_fpe();  return v_act() + c_vfp; endfunction
    function automatic int v_sye();  return v_fpe() + c_vsw + 1; endfunction
    function automatic int v_tot();  return v_sye() + c_vbp; endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at x=%0d y=%0d: actual=%0d expected=%0d", req, mx, my, act, exp);
        end
    endtask

    task automatic check_all();
        bit en = ctrl_en;
        bit hs_on = en && mx >= h_fpe() && mx < h_sye();
        bit vs_on = en && my >= v_fpe() && my < v_sye();
        bit de_on = en && mx < h_act() && my < v_act();
        chk(en ? "R4 px_x" : "R7 px_x", int'(px_x), mx);
        chk(en ? "R4 px_y" : "R7 px_y", int'(px_y), my);
        chk(en ? "R1/R6 de" : "R7 de", int'(de), int'(de_on ^ inv_de));
        chk(en ? "R2/R6 hsync" : "R7 hsync", int'(hsync), int'(hs_on ^ inv_hs));
        chk(en ? "R3/R6 vsync" : "R7 vsync", int'(vsync), int'(vs_on ^ inv_vs));
        chk("R5 frame_start", int'(frame_start), int'(en && mx == 0 && my == 0));
        chk("R8 panel_pwr", int'(panel_pwr), int'(en && ctrl_pwr));
        chk("R9 data_fall", int'(data_fall), int'(en && edge_fall));
    endtask

    // called at a falling edge; applies ce, advances one rising edge, checks
    task automatic cyc(input bit ce);
        pix_ce = ce;
        @(posedge clk);
        #1;
        if (!ctrl_en) begin
            mx = 0; my = 0;
        end else if (ce) begin
            mx++;
            if (mx >= h_tot()) begin
                mx = 0;
                my++;
                if (my >= v_tot()) my = 0;
            end
        end
        check_all();
        @(negedge clk);
    endtask

    task automatic set_cfg(input int wid, hfp, hsw, hbp, lin, vfp, vsw, vbp);
        c_wid = wid; c_hfp = hfp; c_hsw = hsw; c_hbp = hbp;
        c_lin = lin; c_vfp = vfp; c_vsw = vsw; c_vbp = vbp;
        hcfg = {8'(hbp), 8'(hfp), 8'(hsw), 6'(wid), 2'b00};
        vcfg = {8'(vbp), 8'(vfp), 6'(vsw), 10'(lin)};
    endtask

    initial begin
        void'($urandom(32'd20240611));
        set_cfg(0, 1, 2, 0, 3, 0, 0, 1);
        @(negedge clk);
        @(negedge clk);
        // R7 reset state: counters zero, outputs inactive
        chk("R7 reset px_x", int'(px_x), 0);
        chk("R7 reset hsync", int'(hsync), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: power request alone has no effect
        ctrl_pwr = 1'b1;
        edge_fall = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1'b1);

        // directed: continuous pixel enable, two full frames
        ctrl_en = 1'b1;
        for (int i = 0; i < 2 * 22 * 6 + 5; i++) cyc(1'b1);

        // R7: disable mid-frame, then re-enable from the origin
        ctrl_en = 1'b0;
        for (int i = 0; i < 5; i++) cyc(1'b1);
        ctrl_en = 1'b1;
        // R6: inverted polarities
        inv_hs = 1'b1; inv_vs = 1'b1; inv_de = 1'b1;
        for (int i = 0; i < 300; i++) cyc(i % 3 != 0);
        ctrl_en = 1'b0;
        cyc(1'b0);

        // R3 corner: zero vertical porches, single-line frame parts
        set_cfg(1, 0, 0, 0, 0, 0, 0, 0);
        ctrl_en = 1'b1;
        for (int i = 0; i < 200; i++) cyc(1'b1);
        ctrl_en = 1'b0;
        cyc(1'b1);

        // constrained random configurations and pixel-enable patterns
        for (int k = 0; k < 16; k++) begin
            set_cfg($urandom % 2, $urandom % 4, $urandom % 4, $urandom % 4,
                    $urandom % 6, $urandom % 3, $urandom % 4, $urandom % 3);
            inv_hs = 1'($urandom); inv_vs = 1'($urandom); inv_de = 1'($urandom);
            edge_fall = 1'($urandom); ctrl_pwr = 1'($urandom);
            cyc(1'b1);
            ctrl_en = 1'b1;
            for (int i = 0; i < 1500; i++) cyc(($urandom % 4) != 0);
            ctrl_en = 1'b0;
            for (int i = 0; i < 3; i++) cyc(1'b1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule